// File: doc/BRIEF.md
# Debug Breakpoint Control Unit

This block governs breakpoints and debug mode for a small 8-bit processor. A host reads and writes an 8-bit control register and the bytes of a 16-bit counter/compare register through a plain register port. From the processor it receives a strobe that marks a decoded break opcode (opcode 00h), an instruction-fetch strobe and the current program counter. It drives a halt line that stops instruction fetch, a line that holds the processor spinning on the break instruction, a line that tells the core to retire the break opcode as a no-operation, a one-cycle reset request, and a byte stream that carries an acknowledge byte (FFh) to the host link.

The counter/compare register has two roles. In counting mode it decrements on every fetch while the processor runs, and it can raise a break when it reaches zero. In compare mode it stops counting and holds a program-counter value; a fetch at that address raises a break. Any break that halts or spins the processor also queues one acknowledge byte when acknowledge is enabled. That enable bit clears itself when the byte is accepted.

The acknowledge byte leaves on a valid/ready stream. `ack_valid` rises the cycle after the break and stays high, with `ack_data` unchanged, until a cycle where `ack_ready` is also high. At most one byte is pending. Breaks that arrive while a byte is pending add nothing. The control pins are plain levels.

Top module: `brk_ctl`

## Requirements
- R1: After reset, the control register and both counter bytes read 0, and `halt`, `spin_on_brk`, `ack_valid` and `rst_req` are all 0.
- R2: Control bit 7 is the debug flag. `halt` equals that bit. A host write to address 0 sets or clears it from the following cycle on.
- R3: With break enable (bit 6) at 0, `brk_as_nop` is high in any cycle where `brk_op` is high. The control register, `halt`, `spin_on_brk` and `ack_valid` do not change.
- R4: With bit 6 at 1 and the loop bit (bit 4) at 0, `brk_op` sets bit 7 at the next clock edge.
- R5: With bits 6 and 4 both at 1, `brk_op` raises `spin_on_brk` from the next edge and leaves bit 7 unchanged. `spin_on_brk` stays high until a write clears bit 6 or bit 4, and it drops at that write's edge.
- R6: With acknowledge enable (bit 5) at 1, any break (a break opcode with bit 6 set, a PC match, or a counter-zero hit) raises `ack_valid` with `ack_data` = FFh on the next edge. The valid stays high until `ack_ready` is sampled high. At that handshake edge, `ack_valid` falls and bit 5 clears.
- R7: With compare mode (bit 3) at 1, a fetch while running whose `pc` equals the counter register sets bit 7. In this mode the counter does not count.
- R8: With bit 3 at 0 and bit 7 at 0, each fetch decrements the counter by one. While bit 7 is 1, the counter holds.
- R9: With counter-zero break (bit 2) at 1 in counting mode, a fetch that takes the counter from 1 to 0 sets bit 7 at the same edge.
- R10: Writing control with bit 0 = 1 pulses `rst_req` for exactly one cycle, starting the cycle after the write. Bit 0 always reads 0. The other bits take the written value in the same write, so 81h is reset-and-stop and 41h is reset-and-go.
- R11: A hardware event that sets bit 7 wins over a host write that clears bit 7 in the same cycle. The reserved bit 1 always reads 0.
- R12: Address 1 holds counter bits 7:0 and address 2 holds bits 15:8. Both read back what was written. A host write to either byte in a fetch cycle takes effect and suppresses that cycle's decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host write strobe |
| reg_sel | input | 2 | Register address: 0 control, 1 counter low byte, 2 counter high byte |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for `reg_sel` (combinational) |
| brk_op | input | 1 | Break opcode decoded this cycle |
| fetch_en | input | 1 | Instruction fetch this cycle |
| pc | input | 16 | Current program counter |
| halt | output | 1 | Stop fetching instructions |
| spin_on_brk | output | 1 | Hold the processor on the break instruction |
| brk_as_nop | output | 1 | Retire the break opcode as a no-operation |
| rst_req | output | 1 | One-cycle reset request |
| ack_valid | output | 1 | Acknowledge byte available |
| ack_ready | input | 1 | Host link accepts the byte |
| ack_data | output | 8 | Acknowledge byte (FFh) |

## Verification
The two functions that collide are the host write of the control register and the hardware setting of the debug flag. The bench provokes this by driving a control write that clears bit 7 in the same cycle as a break opcode, then reading back bit 7 and `halt`. Two other collisions are checked the same way. A counter byte write is applied during a fetch, and the read-back must show the written value with no decrement. A handshake on the acknowledge stream is observed to clear the enable bit even though the break that caused it is long past.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef struct packed {
    logic dbg;
    logic brk_en;
    logic ack_en;
    logic loop;
    logic pc_brk;
    logic zro_brk;
    logic rsvd;
    logic rst;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              brk_op,
  input  logic              hw_set_ext,
  input  logic              ack_sent,
  output ctrl_t             ctrl_q,
  output logic              brk_hit,
  output logic              brk_as_nop,
  output logic              spin_q,
  output logic              rst_req
);
  ctrl_t ctrl_d;
  logic  brk_halt, brk_loop, hw_set, spin_d;
  logic  unused_rsvd;

  assign unused_rsvd = wdata[1];
  assign brk_as_nop  = brk_op & ~ctrl_q.brk_en;
  assign brk_hit     = brk_op & ctrl_q.brk_en;
  assign brk_halt    = brk_hit & ~ctrl_q.loop;
  assign brk_loop    = brk_hit & ctrl_q.loop;
  assign hw_set      = brk_halt | hw_set_ext;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.dbg     = wdata[7];
      ctrl_d.brk_en  = wdata[6];
      ctrl_d.ack_en  = wdata[5];
      ctrl_d.loop    = wdata[4];
      ctrl_d.pc_brk  = wdata[3];
      ctrl_d.zro_brk = wdata[2];
    end
    if (hw_set)   ctrl_d.dbg    = 1'b1;
    if (ack_sent) ctrl_d.ack_en = 1'b0;
    ctrl_d.rsvd = 1'b0;
    ctrl_d.rst  = 1'b0;
  end

  assign spin_d = (spin_q | brk_loop) & ctrl_d.brk_en & ctrl_d.loop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      spin_q  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      spin_q  <= spin_d;
      rst_req <= wr_ctrl & wdata[0];
    end
  end

  // R4
  brk_halt_sets_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_op && ctrl_q.brk_en && !ctrl_q.loop |=> ctrl_q.dbg);

  // R5
  loop_keeps_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_op && ctrl_q.brk_en && ctrl_q.loop && !wr_ctrl && !hw_set_ext
    |=> spin_q && (ctrl_q.dbg == $past(ctrl_q.dbg)));

  // R11
  hw_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_ext |=> ctrl_q.dbg);

  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !(wr_ctrl && wdata[0]) |=> !rst_req);
endmodule

// File: rtl/brk_cnt.sv
module brk_cnt #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              fetch_en,
  input  logic [CNT_W-1:0]  pc,
  input  logic              running,
  input  logic              pc_mode,
  input  logic              zro_mode,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              pc_hit,
  output logic              zero_hit
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic [NBYTES-1:0] lane_wr;
  logic [CNT_W-1:0]  cnt_d;
  logic              host_wr, dec;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_wr[b] = wr_en && (sel == ADDR_W'(b + 1));
  end

  assign host_wr  = |lane_wr;
  assign dec      = fetch_en & running & ~pc_mode & ~host_wr;
  assign pc_hit   = fetch_en & running & pc_mode & (pc == cnt_q);
  assign zero_hit = dec & zro_mode & (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (dec) cnt_d = cnt_q - CNT_W'(1);
    for (int b = 0; b < NBYTES; b++)
      if (lane_wr[b]) cnt_d[b*BYTE_W +: BYTE_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  cnt_hold_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !host_wr |=> $stable(cnt_q));

  // R7
  cnt_frozen_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_mode && !host_wr |=> $stable(cnt_q));

  // R9
  zero_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> cnt_q == '0);
endmodule

// File: rtl/brk_ack.sv
module brk_ack #(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  ACK_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_en,
  input  logic              brk_event,
  input  logic              ack_ready,
  output logic              ack_valid,
  output logic [BYTE_W-1:0] ack_data,
  output logic              ack_sent
);
  logic pend_q;

  assign ack_valid = pend_q;
  assign ack_data  = BYTE_W'(ACK_BYTE);
  assign ack_sent  = pend_q & ack_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pend_q <= 1'b0;
    else if (ack_sent)                    pend_q <= 1'b0;
    else if (brk_event && ack_en)         pend_q <= 1'b1;
  end

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_ready |=> ack_valid);

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> !ack_valid);
endmodule

// File: rtl/brk_ctl.sv
module brk_ctl
  import brk_pkg::*;
#(
  parameter int         CNT_W    = 16,
  parameter logic [7:0] ACK_BYTE = 8'hFF,
  localparam int        BYTE_W   = CTRL_W,
  localparam int        NBYTES   = CNT_W / BYTE_W,
  localparam int        ADDR_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              brk_op,
  input  logic              fetch_en,
  input  logic [CNT_W-1:0]  pc,
  output logic              halt,
  output logic              spin_on_brk,
  output logic              brk_as_nop,
  output logic              rst_req,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [BYTE_W-1:0] ack_data
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_ctrl, brk_hit, pc_hit, zero_hit, ack_sent;

  assign wr_ctrl = reg_wr_en && (reg_sel == '0);

  brk_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wdata      (reg_wdata),
    .brk_op     (brk_op),
    .hw_set_ext (pc_hit | zero_hit),
    .ack_sent   (ack_sent),
    .ctrl_q     (ctrl_q),
    .brk_hit    (brk_hit),
    .brk_as_nop (brk_as_nop),
    .spin_q     (spin_on_brk),
    .rst_req    (rst_req)
  );

  brk_cnt #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .fetch_en (fetch_en),
    .pc       (pc),
    .running  (~ctrl_q.dbg),
    .pc_mode  (ctrl_q.pc_brk),
    .zro_mode (ctrl_q.zro_brk),
    .cnt_q    (cnt_q),
    .pc_hit   (pc_hit),
    .zero_hit (zero_hit)
  );

  brk_ack #(.BYTE_W(BYTE_W), .ACK_BYTE(ACK_BYTE)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_en    (ctrl_q.ack_en),
    .brk_event (brk_hit | pc_hit | zero_hit),
    .ack_ready (ack_ready),
    .ack_valid (ack_valid),
    .ack_data  (ack_data),
    .ack_sent  (ack_sent)
  );

  assign halt = ctrl_q.dbg;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == '0) reg_rdata = ctrl_q;
    for (int b = 0; b < NBYTES; b++)
      if (reg_sel == ADDR_W'(b + 1)) reg_rdata = cnt_q[b*BYTE_W +: BYTE_W];
  end

  // R3
  nop_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_as_nop && !reg_wr_en && !fetch_en && !ack_valid |=> $stable(ctrl_q) && !ack_valid);

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == '0 |-> reg_rdata[1:0] == 2'b00);
endmodule

// File: tb/tb_brk_ctl.sv
module tb_brk_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        brk_op = 1'b0, fetch_en = 1'b0, ack_ready = 1'b0;
  logic [15:0] pc = '0;
  logic        halt, spin_on_brk, brk_as_nop, rst_req, ack_valid;
  logic [7:0]  ack_data;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_ctl dut (.*);

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] sel, logic [7:0] exp);
    reg_sel = sel;
    #1;
    chk(req, "read", {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic pulse_brk(output logic nop_seen);
    @(negedge clk);
    brk_op = 1'b1;
    #1 nop_seen = brk_as_nop;
    @(negedge clk);
    brk_op = 1'b0;
  endtask

  task automatic fetch_n(int n, logic [15:0] pcv);
    @(negedge clk);
    fetch_en = 1'b1; pc = pcv;
    repeat (n) @(negedge clk);
    fetch_en = 1'b0;
  endtask

  task automatic t_reset();
    rd("R1", 2'd0, 8'h00); rd("R1", 2'd1, 8'h00); rd("R1", 2'd2, 8'h00);
    chk("R1", "halt", halt, 0); chk("R1", "spin", spin_on_brk, 0);
    chk("R1", "ack_valid", ack_valid, 0); chk("R1", "rst_req", rst_req, 0);
  endtask

  task automatic t_host_dbg();
    wr(2'd0, 8'h80);
    chk("R2", "halt set", halt, 1); rd("R2", 2'd0, 8'h80);
    wr(2'd0, 8'h00);
    chk("R2", "halt clr", halt, 0);
  endtask

  task automatic t_nop();
    logic n;
    wr(2'd0, 8'h20);
    pulse_brk(n);
    chk("R3", "nop", n, 1);
    rd("R3", 2'd0, 8'h20);
    chk("R3", "halt", halt, 0); chk("R3", "spin", spin_on_brk, 0);
    chk("R3", "ack_valid", ack_valid, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_halt_ack();
    logic n;
    wr(2'd0, 8'h60);
    pulse_brk(n);
    chk("R3", "nop when enabled", n, 0);
    chk("R4", "halt", halt, 1); rd("R4", 2'd0, 8'hE0);
    chk("R6", "ack_valid", ack_valid, 1); chk("R6", "ack_data", ack_data, 8'hFF);
    repeat (3) @(negedge clk);
    chk("R6", "ack held", ack_valid, 1); rd("R6", 2'd0, 8'hE0);
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
    chk("R6", "ack dropped", ack_valid, 0); rd("R6", 2'd0, 8'hC0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_loop();
    logic n;
    wr(2'd0, 8'h50);
    pulse_brk(n);
    chk("R5", "spin", spin_on_brk, 1); chk("R5", "halt", halt, 0);
    rd("R5", 2'd0, 8'h50);
    repeat (4) @(negedge clk);
    chk("R5", "spin held", spin_on_brk, 1);
    wr(2'd0, 8'h40);
    chk("R5", "spin released", spin_on_brk, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_count();
    wr(2'd1, 8'h05); wr(2'd2, 8'h00);
    rd("R12", 2'd1, 8'h05);
    fetch_n(3, 16'h0100);
    rd("R8", 2'd1, 8'h02);
    wr(2'd0, 8'h80);
    fetch_n(2, 16'h0100);
    rd("R8", 2'd1, 8'h02);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h12);
    rd("R12", 2'd2, 8'h12);
    @(negedge clk);
    fetch_en = 1'b1; reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h40;
    @(negedge clk);
    fetch_en = 1'b0; reg_wr_en = 1'b0;
    rd("R12", 2'd1, 8'h40); rd("R12", 2'd2, 8'h12);
  endtask

  task automatic t_zero();
    wr(2'd1, 8'h02); wr(2'd2, 8'h00);
    wr(2'd0, 8'h04);
    fetch_n(1, 16'h0200);
    rd("R9", 2'd1, 8'h01); chk("R9", "no halt yet", halt, 0);
    fetch_n(1, 16'h0201);
    rd("R9", 2'd1, 8'h00); chk("R9", "halt", halt, 1);
    rd("R9", 2'd0, 8'h84);
    fetch_n(2, 16'h0202);
    rd("R8", 2'd1, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_pcmatch();
    wr(2'd1, 8'h34); wr(2'd2, 8'h12);
    wr(2'd0, 8'h28);
    fetch_n(3, 16'h1000);
    rd("R7", 2'd1, 8'h34); rd("R7", 2'd2, 8'h12);
    chk("R7", "no halt", halt, 0);
    fetch_n(1, 16'h1234);
    chk("R7", "halt", halt, 1);
    chk("R6", "ack on pc match", ack_valid, 1);
    @(negedge clk); ack_ready = 1'b1;
    @(negedge clk); ack_ready = 1'b0;
    chk("R6", "ack done", ack_valid, 0); rd("R6", 2'd0, 8'h88);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_rst_bit();
    wr(2'd0, 8'h81);
    chk("R10", "rst_req pulse", rst_req, 1); chk("R10", "halt stop", halt, 1);
    rd("R10", 2'd0, 8'h80);
    @(negedge clk);
    chk("R10", "rst_req one cycle", rst_req, 0);
    wr(2'd0, 8'h41);
    chk("R10", "rst_req go", rst_req, 1); chk("R10", "halt go", halt, 0);
    rd("R10", 2'd0, 8'h40);
    @(negedge clk);
    chk("R10", "rst_req low", rst_req, 0);
  endtask

  task automatic t_priority();
    wr(2'd0, 8'h40);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h40; brk_op = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; brk_op = 1'b0;
    chk("R11", "hw wins", halt, 1); rd("R11", 2'd0, 8'hC0);
    wr(2'd0, 8'h02);
    rd("R11", 2'd0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_dbg();
    t_nop();
    t_halt_ack();
    t_loop();
    t_count();
    t_zero();
    t_pcmatch();
    t_rst_bit();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule